// File: doc/BRIEF.md
# Debug Bus Access Arbiter

This block shares a processor's local bus with a debug controller that issues single memory-access commands while the core keeps running. When a memory command arrives and the core is running, the arbiter stalls instruction fetch and waits until the processor's current bus activity has finished. It then drives one debug bus cycle and gives the bus back. Register-access commands touch processor state, so the arbiter rejects them while the core runs. When the core is halted, memory commands get the bus at once and register commands are accepted.

The command interface is valid/ready. The command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when no command is outstanding, so only one command is in flight at a time. While `cmd_ready` is low the source must hold its command. The response is a one-cycle `rsp_valid` pulse that the consumer cannot stall; `rsp_reject` and `rsp_rdata` are valid during that pulse. While the debug side does not hold the bus, the processor's master signals pass straight through to the bus.

Top module: `dbg_bus_arbiter`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `fetch_stall`, `dbg_grant` and `rsp_valid` are 0.
- R2: A register command (`cmd_kind`=1), accepted while `core_halted`=0, yields `rsp_valid`=1 with `rsp_reject`=1 in the cycle after acceptance. The bus is never granted to the debug side for it.
- R3: A register command accepted while `core_halted`=1 yields `rsp_valid`=1 with `rsp_reject`=0 in the cycle after acceptance, again without a debug grant.
- R4: A memory command (`cmd_kind`=0), accepted while `core_halted`=0, raises `fetch_stall` in the cycle after acceptance. `dbg_grant` stays 0 in that cycle and in the next one (the request and drain phases).
- R5: In the drain phase, `dbg_grant` stays 0 for as long as `core_bus_busy` is 1. `dbg_grant` rises in the cycle after the first edge at which `core_bus_busy` is sampled 0.
- R6: A memory command accepted while `core_halted`=1 raises `dbg_grant` in the cycle after acceptance, and `fetch_stall` stays 0 throughout.
- R7: While `dbg_grant`=1, `bus_req`=1 and `bus_addr`, `bus_wdata` and `bus_write` carry the accepted command's values. While `dbg_grant`=0, the four bus outputs follow `cpu_req`, `cpu_addr`, `cpu_wdata` and `cpu_write`.
- R8: In the cycle after an edge where `bus_ack`=1 with `dbg_grant`=1, the arbiter pulses `rsp_valid` for one cycle with `rsp_reject`=0 and `rsp_rdata` equal to the `bus_rdata` sampled at that edge. In the same cycle `dbg_grant` and `fetch_stall` are 0.
- R9: `cmd_ready` is 0 from acceptance until the cycle after the response pulse. A `cmd_valid` held during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Debug command valid |
| cmd_ready | output | 1 | Arbiter can take a command |
| cmd_kind | input | 1 | 0 memory access, 1 register access |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_reject | output | 1 | Command refused (valid with rsp_valid) |
| rsp_rdata | output | DATA_W | Read data (valid with rsp_valid) |
| core_halted | input | 1 | Processor is halted |
| core_bus_busy | input | 1 | Processor has bus activity in progress |
| fetch_stall | output | 1 | Stall request to instruction fetch |
| dbg_grant | output | 1 | Bus currently owned by debug side |
| cpu_req | input | 1 | Processor bus request |
| cpu_write | input | 1 | Processor write enable |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| bus_req | output | 1 | Shared bus request |
| bus_write | output | 1 | Shared bus write enable |
| bus_addr | output | ADDR_W | Shared bus address |
| bus_wdata | output | DATA_W | Shared bus write data |
| bus_rdata | input | DATA_W | Shared bus read data |
| bus_ack | input | 1 | Shared bus cycle complete |

## Verification
Two things can fall in the same cycle. The processor can still report bus activity in the cycle after the stall is raised, and a new command can be offered while the previous one is still draining. The bench holds `core_bus_busy` high for several drain cycles and keeps `cmd_valid` asserted at the same time. It then judges that the grant waits exactly one cycle past the first idle sample and that the held command is not taken before the response pulse has gone.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_STALL,
    ST_DRAIN,
    ST_DEBUG_CYCLE,
    ST_RELEASE
  } arb_state_t;

  localparam logic KIND_MEM = 1'b0;
  localparam logic KIND_REG = 1'b1;
endpackage

// File: rtl/dbg_arb_fsm.sv
module dbg_arb_fsm
  import dbg_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_kind,
  input  logic core_halted,
  input  logic core_bus_busy,
  input  logic bus_ack,
  output logic accept,
  output logic cmd_ready,
  output logic fetch_stall,
  output logic dbg_grant,
  output logic rsp_valid,
  output logic rsp_reject
);
  arb_state_t st_q, st_d;
  logic stall_q, reject_q;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign dbg_grant = (st_q == ST_DEBUG_CYCLE);
  assign rsp_valid = (st_q == ST_RELEASE);
  assign rsp_reject = rsp_valid && reject_q;
  assign fetch_stall = stall_q &&
    ((st_q == ST_REQ_STALL) || (st_q == ST_DRAIN) || (st_q == ST_DEBUG_CYCLE));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (cmd_kind == KIND_REG) st_d = ST_RELEASE;
        else if (core_halted)     st_d = ST_DEBUG_CYCLE;
        else                      st_d = ST_REQ_STALL;
      end
      ST_REQ_STALL:   st_d = ST_DRAIN;
      ST_DRAIN:       if (!core_bus_busy) st_d = ST_DEBUG_CYCLE;
      ST_DEBUG_CYCLE: if (bus_ack) st_d = ST_RELEASE;
      ST_RELEASE:     st_d = ST_IDLE;
      default:        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      stall_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        stall_q  <= (cmd_kind == KIND_MEM) && !core_halted;
        reject_q <= (cmd_kind == KIND_REG) && !core_halted;
      end
    end
  end
endmodule

// File: rtl/dbg_arb_cmd_hold.sv
module dbg_arb_cmd_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              hold_write,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_wdata,
  output logic [DATA_W-1:0] hold_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_write <= 1'b0;
      hold_addr  <= '0;
      hold_wdata <= '0;
      hold_rdata <= '0;
    end else if (accept) begin
      hold_write <= cmd_write;
      hold_addr  <= cmd_addr;
      hold_wdata <= cmd_wdata;
      hold_rdata <= '0;
    end else if (capture) begin
      hold_rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/dbg_arb_bus_mux.sv
module dbg_arb_bus_mux #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              sel_dbg,
  input  logic              cpu_req,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dbg_write,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  always_comb begin
    if (sel_dbg) begin
      bus_req   = 1'b1;
      bus_write = dbg_write;
      bus_addr  = dbg_addr;
      bus_wdata = dbg_wdata;
    end else begin
      bus_req   = cpu_req;
      bus_write = cpu_write;
      bus_addr  = cpu_addr;
      bus_wdata = cpu_wdata;
    end
  end
endmodule

// File: rtl/dbg_bus_arbiter.sv
module dbg_bus_arbiter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_kind,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_reject,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              core_halted,
  input  logic              core_bus_busy,
  output logic              fetch_stall,
  output logic              dbg_grant,
  input  logic              cpu_req,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  logic              accept;
  logic              hold_write;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_wdata;
  logic [DATA_W-1:0] hold_rdata;

  dbg_arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .core_halted(core_halted), .core_bus_busy(core_bus_busy), .bus_ack(bus_ack),
    .accept(accept), .cmd_ready(cmd_ready), .fetch_stall(fetch_stall),
    .dbg_grant(dbg_grant), .rsp_valid(rsp_valid), .rsp_reject(rsp_reject)
  );

  dbg_arb_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .capture(dbg_grant && bus_ack),
    .bus_rdata(bus_rdata), .hold_write(hold_write), .hold_addr(hold_addr),
    .hold_wdata(hold_wdata), .hold_rdata(hold_rdata)
  );

  dbg_arb_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_dbg(dbg_grant), .cpu_req(cpu_req), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .dbg_write(hold_write),
    .dbg_addr(hold_addr), .dbg_wdata(hold_wdata), .bus_req(bus_req),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  assign rsp_rdata = rsp_valid ? hold_rdata : '0;
endmodule

// File: rtl/dbg_bus_arbiter_chk.sv
module dbg_bus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_reject,
  input logic core_bus_busy,
  input logic fetch_stall,
  input logic dbg_grant,
  input logic bus_req,
  input logic bus_ack
);
  // R1
  ready_only_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!dbg_grant && !fetch_stall && !rsp_valid));

  // R4
  stall_before_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dbg_grant) && fetch_stall) |-> $past(fetch_stall));

  // R5
  grant_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dbg_grant) && fetch_stall) |-> !$past(core_bus_busy));

  // R7
  grant_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_grant |-> bus_req);

  // R8
  resp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_grant && bus_ack) |=> (rsp_valid && !rsp_reject && !dbg_grant && !fetch_stall));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && cmd_ready));

  // R2
  reject_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reject |-> (rsp_valid && !dbg_grant));
endmodule

bind dbg_bus_arbiter dbg_bus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_reject(rsp_reject), .core_bus_busy(core_bus_busy), .fetch_stall(fetch_stall),
  .dbg_grant(dbg_grant), .bus_req(bus_req), .bus_ack(bus_ack)
);

// File: tb/dbg_bus_arbiter_tb_top.sv
module dbg_bus_arbiter_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_kind = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic core_halted = 0, core_bus_busy = 0;
  logic cpu_req = 0, cpu_write = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ack = 0;
  logic cmd_ready, rsp_valid, rsp_reject, fetch_stall, dbg_grant;
  logic bus_req, bus_write;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_reject(rsp_reject),
    .rsp_rdata(rsp_rdata), .core_halted(core_halted), .core_bus_busy(core_bus_busy),
    .fetch_stall(fetch_stall), .dbg_grant(dbg_grant), .cpu_req(cpu_req),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic offer(input logic kind, input logic wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid = 1; cmd_kind = kind; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
  endtask

  task automatic t_reset();
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "fetch_stall", fetch_stall, 0);
    chk("R1", "dbg_grant", dbg_grant, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_reg_running();
    core_halted = 0;
    offer(1, 0, 32'h10, 0);
    step();
    cmd_valid = 0;
    chk("R2", "rsp_valid", rsp_valid, 1);
    chk("R2", "rsp_reject", rsp_reject, 1);
    chk("R2", "dbg_grant", dbg_grant, 0);
    step();
    chk("R9", "ready back", cmd_ready, 1);
  endtask

  task automatic t_reg_halted();
    core_halted = 1;
    offer(1, 1, 32'h20, 32'h5);
    step();
    cmd_valid = 0;
    chk("R3", "rsp_valid", rsp_valid, 1);
    chk("R3", "rsp_reject", rsp_reject, 0);
    chk("R3", "dbg_grant", dbg_grant, 0);
    step();
    core_halted = 0;
  endtask

  task automatic t_mem_running_read();
    core_halted = 0; core_bus_busy = 1;
    cpu_req = 1; cpu_addr = 32'hC0DE_0000; cpu_write = 0; cpu_wdata = 32'h1111;
    offer(0, 0, 32'hA000_0040, 0);
    step();
    chk("R4", "stall raised", fetch_stall, 1);
    chk("R4", "no grant in request", dbg_grant, 0);
    chk("R9", "ready low", cmd_ready, 0);
    cmd_kind = 1;  // keep offering a different command: must not be taken
    step();
    chk("R4", "no grant in drain", dbg_grant, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5", "held off while busy", dbg_grant, 0);
      chk("R7", "cpu addr passes", bus_addr, 32'hC0DE_0000);
    end
    core_bus_busy = 0;
    step();
    chk("R5", "grant after idle", dbg_grant, 1);
    chk("R7", "bus_req", bus_req, 1);
    chk("R7", "dbg addr", bus_addr, 32'hA000_0040);
    chk("R7", "dbg write", bus_write, 0);
    chk("R4", "stall during cycle", fetch_stall, 1);
    step();
    chk("R8", "no early response", rsp_valid, 0);
    bus_ack = 1; bus_rdata = 32'hFEED_BEEF;
    step();
    bus_ack = 0; bus_rdata = 32'h0;
    chk("R8", "rsp_valid", rsp_valid, 1);
    chk("R8", "rsp_reject", rsp_reject, 0);
    chk("R8", "rdata", rsp_rdata, 32'hFEED_BEEF);
    chk("R8", "stall released", fetch_stall, 0);
    chk("R8", "grant dropped", dbg_grant, 0);
    chk("R7", "cpu back on bus", bus_addr, 32'hC0DE_0000);
    chk("R9", "ready low in pulse", cmd_ready, 0);
    cmd_valid = 0;
    step();
    chk("R9", "held command not taken", rsp_valid, 0);
    chk("R9", "idle again", fetch_stall, 0);
    cpu_req = 0;
  endtask

  task automatic t_mem_halted_write();
    core_halted = 1; core_bus_busy = 1;
    offer(0, 1, 32'h0000_0100, 32'hABCD_1234);
    step();
    cmd_valid = 0;
    chk("R6", "immediate grant", dbg_grant, 1);
    chk("R6", "no stall", fetch_stall, 0);
    chk("R7", "write addr", bus_addr, 32'h0000_0100);
    chk("R7", "write data", bus_wdata, 32'hABCD_1234);
    chk("R7", "write dir", bus_write, 1);
    bus_ack = 1;
    step();
    bus_ack = 0;
    chk("R8", "rsp_valid", rsp_valid, 1);
    chk("R6", "no stall in release", fetch_stall, 0);
    step();
    core_halted = 0; core_bus_busy = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_reg_running();
    t_reg_halted();
    t_mem_running_read();
    t_mem_halted_write();
    step();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule